// File: doc/BRIEF.md
# Smart Card Receive Status Checker

This block sits behind a smart card character receiver. Each byte that the receiver has already deserialized arrives with a one-cycle valid strobe and a parity-check result. The byte goes into a small receive FIFO. A processor drains the FIFO through a registered data read port. The block also keeps a status register that the processor polls. That register holds sticky error flags, the FIFO occupancy indications, a last-byte control bit and a captured ninth data bit.

Error flags are cleared when the processor reads the status register. An overrun locks the FIFO against further writes until that read happens. Parity and overrun errors drive a level receive-error interrupt.

At the end of a block of characters, the processor sets the last-byte bit while the final byte is still on the wire. When that byte completes, the running CRC-16 or LRC is compared with its expected residue. A mismatch is flagged. The accumulators are restarted by a block-start pulse and again after every such check.

Top module: `card_rx_status`

## Requirements
- R1: After reset the FIFO is empty, the read data is 0x00, the interrupt is low, and a status read returns 0x04. Status bit layout: bit0 parity error, bit1 overrun, bit2 FIFO empty, bit3 FIFO full, bit4 check error, bit5 last-byte, bit6 ninth bit, bit7 zero.
- R2: The FIFO holds 4 bytes and returns them in arrival order. A data read presents the byte on `rdData` one clock after the read strobe. A data read of an empty FIFO leaves `rdData` unchanged.
- R3: A byte that arrives while the FIFO holds 4 entries sets the overrun flag (bit1) and is not stored.
- R4: While the overrun flag is set, every incoming byte is discarded, even when the FIFO has space. After a status read clears the flag, bytes are stored again.
- R5: A byte that arrives with its parity-error input high sets the parity flag (bit0). The byte is still stored.
- R6: `rxErrIrq` is high exactly while the parity or overrun flag is set. An empty FIFO never raises it.
- R7: A status read returns the flag values from before the read and clears bits 0, 1 and 4. If an error event coincides with the read, that flag stays set.
- R8: Bit3 reads 1 when the FIFO holds 4 entries. Bit2 reads 1 when it holds none.
- R9: Writing the status register with `statWrLast`=1 sets bit5. When the next byte completes with bit5 set in CRC mode (`crcMode`=1), the CRC is computed over all bytes since the block started (polynomial 0x1021, preset 0xFFFF, MSB first). If that CRC is not 0x1D0F, bit4 is set. Bit5 clears after the check.
- R10: In LRC mode (`crcMode`=0), the same end-of-block check sets bit4 when the XOR of all bytes since the block started is not 0x00.
- R11: Both accumulators restart on a `blockStart` pulse and immediately after each end-of-block check.
- R12: A `ninthEdge` pulse with `syncNineMode` high latches `ioLine` into bit6. With `syncNineMode` low, the pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| byteValid | input | 1 | One-cycle strobe: a received byte is complete |
| byteData | input | 8 | Received byte |
| byteParityErr | input | 1 | Parity check failed for this byte |
| blockStart | input | 1 | Restart the CRC and LRC accumulators |
| crcMode | input | 1 | 1 = CRC-16 check, 0 = LRC check |
| syncNineMode | input | 1 | Synchronous mode with 9-bit format selected |
| ninthEdge | input | 1 | Pulse at the ninth clock rising edge |
| ioLine | input | 1 | Current value of the card data line |
| dataRdEn | input | 1 | Processor read of the receive data register |
| rdData | output | 8 | Registered receive data |
| statRdEn | input | 1 | Processor read of the status register |
| statWrEn | input | 1 | Processor write of the status register |
| statWrLast | input | 1 | Last-byte bit value written |
| statusOut | output | 8 | Registered status read data |
| rxErrIrq | output | 1 | Receive-error interrupt |

## Verification
The bench fills the FIFO and sends one byte too many. A design that stored that byte, or that accepted bytes again before the status read, would return the wrong data sequence. A status read is issued in the same cycle as a parity error; a design that let the clear win would lose the error. The bench sends a CRC block whose last two bytes are chosen to give the exact residue, and a corrupted block alongside it. It also runs back-to-back LRC blocks with no restart pulse between them; a design that did not restart the accumulators after a check would flag a false error on the second block. Reading an empty FIFO and pulsing the ninth-bit edge outside the 9-bit mode confirm that neither changes visible state.

// File: rtl/card_rx_pkg.sv
package card_rx_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic accStep;
    logic accClear;
  } rxStrobeT;

  localparam logic [15:0] CRC_POLY    = 16'h1021;
  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE = 16'h1D0F;
endpackage

// File: rtl/card_rx_data.sv
module card_rx_data
  import card_rx_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobeT          strobe,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              crcMode,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              residueOk,
  output logic [BYTE_W-1:0] rdData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic [15:0]       crcAcc, crcNext;
  logic [BYTE_W-1:0] lrcAcc, lrcNext;

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [BYTE_W-1:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) mem[g] <= '0;
      else if (strobe.push && wrPtr == PTR_W'(g)) mem[g] <= byteData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      rdData <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (strobe.pop) begin
        rdData <= mem[rdPtr];
        rdPtr  <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      end
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign fifoFull  = (count == CNT_W'(DEPTH));
  assign fifoEmpty = (count == '0);

  assign crcNext = crcStep(crcAcc, byteData);
  assign lrcNext = lrcAcc ^ byteData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcAcc <= CRC_PRESET;
      lrcAcc <= '0;
    end else if (strobe.accClear) begin
      crcAcc <= CRC_PRESET;
      lrcAcc <= '0;
    end else if (strobe.accStep) begin
      crcAcc <= crcNext;
      lrcAcc <= lrcNext;
    end
  end

  assign residueOk = crcMode ? (crcNext == CRC_RESIDUE) : (lrcNext == '0);
endmodule

// File: rtl/card_rx_ctrl.sv
module card_rx_ctrl
  import card_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     byteValid,
  input  logic     byteParityErr,
  input  logic     blockStart,
  input  logic     syncNineMode,
  input  logic     ninthEdge,
  input  logic     ioLine,
  input  logic     dataRdEn,
  input  logic     statRdEn,
  input  logic     statWrEn,
  input  logic     statWrLast,
  input  logic     fifoFull,
  input  logic     fifoEmpty,
  input  logic     residueOk,
  output rxStrobeT strobe,
  output logic [7:0] statusOut,
  output logic     rxErrIrq
);
  logic parFlag, ovrFlag, chkFlag, lastBit, ninthBit;
  logic parEvent, ovrEvent, chkEvent, checkNow;

  assign ovrEvent = byteValid & fifoFull;
  assign parEvent = byteValid & byteParityErr;
  assign checkNow = byteValid & lastBit;
  assign chkEvent = checkNow & ~residueOk;

  assign strobe.push     = byteValid & ~ovrFlag & ~fifoFull;
  assign strobe.pop      = dataRdEn & ~fifoEmpty;
  assign strobe.accStep  = byteValid;
  assign strobe.accClear = blockStart | checkNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parFlag   <= 1'b0;
      ovrFlag   <= 1'b0;
      chkFlag   <= 1'b0;
      lastBit   <= 1'b0;
      ninthBit  <= 1'b0;
      statusOut <= '0;
    end else begin
      parFlag <= parEvent | (parFlag & ~statRdEn);
      ovrFlag <= ovrEvent | (ovrFlag & ~statRdEn);
      chkFlag <= chkEvent | (chkFlag & ~statRdEn);
      if (checkNow)      lastBit <= 1'b0;
      else if (statWrEn) lastBit <= statWrLast;
      if (syncNineMode && ninthEdge) ninthBit <= ioLine;
      if (statRdEn)
        statusOut <= {1'b0, ninthBit, lastBit, chkFlag, fifoFull, fifoEmpty, ovrFlag, parFlag};
    end
  end

  assign rxErrIrq = parFlag | ovrFlag;
endmodule

// File: rtl/card_rx_status.sv
module card_rx_status
  import card_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  input  logic       byteParityErr,
  input  logic       blockStart,
  input  logic       crcMode,
  input  logic       syncNineMode,
  input  logic       ninthEdge,
  input  logic       ioLine,
  input  logic       dataRdEn,
  output logic [7:0] rdData,
  input  logic       statRdEn,
  input  logic       statWrEn,
  input  logic       statWrLast,
  output logic [7:0] statusOut,
  output logic       rxErrIrq
);
  rxStrobeT strobe;
  logic fifoFull, fifoEmpty, residueOk;

  card_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteParityErr(byteParityErr),
    .blockStart(blockStart), .syncNineMode(syncNineMode), .ninthEdge(ninthEdge),
    .ioLine(ioLine), .dataRdEn(dataRdEn), .statRdEn(statRdEn), .statWrEn(statWrEn),
    .statWrLast(statWrLast), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .residueOk(residueOk), .strobe(strobe), .statusOut(statusOut), .rxErrIrq(rxErrIrq)
  );

  card_rx_data #(.DEPTH(DEPTH), .BYTE_W(8)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteData(byteData), .crcMode(crcMode),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .residueOk(residueOk), .rdData(rdData)
  );
endmodule

// File: rtl/card_rx_checker.sv
module card_rx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       byteValid,
  input logic       dataRdEn,
  input logic       statRdEn,
  input logic       rxErrIrq,
  input logic [7:0] rdData,
  input logic       fifoFull,
  input logic       fifoEmpty
);
  // R2: reading an empty FIFO keeps the read data
  a_r2_empty_read_holds: assert property (@(posedge clk) disable iff (!rstN)
    (dataRdEn && fifoEmpty) |=> $stable(rdData));

  // R3: a byte into a full FIFO raises the error interrupt next cycle
  a_r3_overrun_flags: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && fifoFull) |=> rxErrIrq);

  // R6: the interrupt only rises after an incoming byte
  a_r6_irq_from_byte: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxErrIrq) |-> $past(byteValid));

  // R7: a status read with no coinciding byte clears the interrupt sources
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (statRdEn && !byteValid) |=> !rxErrIrq);

  // R8: full and empty never together
  a_r8_full_empty_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty));
endmodule

bind card_rx_status card_rx_checker u_chk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .dataRdEn(dataRdEn),
  .statRdEn(statRdEn), .rxErrIrq(rxErrIrq), .rdData(rdData),
  .fifoFull(fifoFull), .fifoEmpty(fifoEmpty)
);

// File: tb/test_card_rx_status.sv
module test_card_rx_status;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic byteValid = 0, byteParityErr = 0, blockStart = 0, crcMode = 1;
  logic syncNineMode = 0, ninthEdge = 0, ioLine = 0;
  logic dataRdEn = 0, statRdEn = 0, statWrEn = 0, statWrLast = 0;
  logic [7:0] byteData = 0;
  logic [7:0] rdData, statusOut;
  logic rxErrIrq;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_rx_status i_card_rx_status (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .byteParityErr(byteParityErr), .blockStart(blockStart), .crcMode(crcMode),
    .syncNineMode(syncNineMode), .ninthEdge(ninthEdge), .ioLine(ioLine),
    .dataRdEn(dataRdEn), .rdData(rdData), .statRdEn(statRdEn), .statWrEn(statWrEn),
    .statWrLast(statWrLast), .statusOut(statusOut), .rxErrIrq(rxErrIrq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crcB(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[15] ^ d[i];
      r = {r[14:0], 1'b0};
      if (fb) r ^= 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [15:0] findTrail(input logic [15:0] c);
    for (int v = 0; v < 65536; v++)
      if (crcB(crcB(c, v[15:8]), v[7:0]) == 16'h1D0F) return v[15:0];
    return 16'h0;
  endfunction

  task automatic sendByte(input logic [7:0] d, input logic par = 1'b0);
    @(negedge clk); byteValid = 1; byteData = d; byteParityErr = par;
    @(negedge clk); byteValid = 0; byteParityErr = 0;
  endtask

  task automatic readStat(output logic [7:0] s);
    @(negedge clk); statRdEn = 1;
    @(negedge clk); statRdEn = 0; s = statusOut;
  endtask

  task automatic readData(output logic [7:0] d);
    @(negedge clk); dataRdEn = 1;
    @(negedge clk); dataRdEn = 0; d = rdData;
  endtask

  task automatic setLast();
    @(negedge clk); statWrEn = 1; statWrLast = 1;
    @(negedge clk); statWrEn = 0; statWrLast = 0;
  endtask

  task automatic startBlock();
    @(negedge clk); blockStart = 1;
    @(negedge clk); blockStart = 0;
  endtask

  task automatic flush();
    logic [7:0] x;
    for (int i = 0; i < 4; i++) readData(x);
    readStat(x);
  endtask

  task automatic testReset();
    logic [7:0] s;
    chk("R1 rdData", rdData, 8'h00);
    chk("R6 irq idle with empty FIFO", rxErrIrq, 1'b0);
    readStat(s);
    chk("R1 status after reset", s, 8'h04);
  endtask

  task automatic testFifo();
    logic [7:0] s, d;
    for (int i = 1; i <= 4; i++) sendByte(8'(i * 8'h11));
    readStat(s);
    chk("R8 full, not empty", s[3:2], 2'b10);
    for (int i = 1; i <= 4; i++) begin
      readData(d);
      chk("R2 order", d, 8'(i * 8'h11));
    end
    readData(d);
    chk("R2 empty read holds", d, 8'h44);
    readStat(s);
    chk("R8 empty after drain", s[3:2], 2'b01);
  endtask

  task automatic testOverrun();
    logic [7:0] s, d;
    for (int i = 0; i < 4; i++) sendByte(8'hA1 + 8'(i));
    sendByte(8'hA5);
    chk("R3 irq on overrun", rxErrIrq, 1'b1);
    readData(d);
    chk("R3 head byte", d, 8'hA1);
    sendByte(8'hA6);
    readStat(s);
    chk("R3 overrun flag", s[1:0], 2'b10);
    chk("R7 irq cleared by read", rxErrIrq, 1'b0);
    sendByte(8'hA7);
    for (int i = 0; i < 3; i++) begin
      readData(d);
      chk("R4 kept bytes", d, 8'hA2 + 8'(i));
    end
    readData(d);
    chk("R4 lockout dropped A6, A7 stored", d, 8'hA7);
    readStat(s);
  endtask

  task automatic testParity();
    logic [7:0] s, d;
    sendByte(8'h66, 1'b1);
    chk("R6 irq on parity", rxErrIrq, 1'b1);
    readStat(s);
    chk("R5 parity flag", s[0], 1'b1);
    readData(d);
    chk("R5 byte stored", d, 8'h66);
    @(negedge clk); statRdEn = 1; byteValid = 1; byteData = 8'h99; byteParityErr = 1;
    @(negedge clk); statRdEn = 0; byteValid = 0; byteParityErr = 0;
    chk("R7 pre-read value", statusOut[0], 1'b0);
    chk("R7 event beats clear", rxErrIrq, 1'b1);
    readStat(s);
    chk("R7 flag kept", s[0], 1'b1);
    flush();
  endtask

  task automatic testCrc();
    logic [7:0] s;
    logic [15:0] c, t;
    crcMode = 1;
    startBlock();
    sendByte(8'h31); sendByte(8'h32);
    c = crcB(crcB(16'hFFFF, 8'h31), 8'h32);
    t = findTrail(c);
    sendByte(t[15:8]);
    setLast();
    readStat(s);
    chk("R9 last bit set", s[5], 1'b1);
    sendByte(t[7:0]);
    readStat(s);
    chk("R9 good CRC no error", s[4], 1'b0);
    chk("R9 last bit cleared", s[5], 1'b0);
    flush();
    startBlock();
    sendByte(8'h31);
    setLast();
    sendByte(8'h55);
    c = crcB(crcB(16'hFFFF, 8'h31), 8'h55);
    readStat(s);
    chk("R9 bad CRC error", s[4], (c != 16'h1D0F));
    readStat(s);
    chk("R7 check flag cleared", s[4], 1'b0);
    flush();
  endtask

  task automatic testLrc();
    logic [7:0] s;
    crcMode = 0;
    startBlock();
    sendByte(8'h12); setLast(); sendByte(8'h34);
    readStat(s);
    chk("R10 LRC error", s[4], 1'b1);
    flush();
    sendByte(8'h5A); setLast(); sendByte(8'h5A);
    readStat(s);
    chk("R11 restart after check", s[4], 1'b0);
    flush();
    sendByte(8'h77);
    startBlock();
    sendByte(8'h3C); setLast(); sendByte(8'h3C);
    readStat(s);
    chk("R11 restart on blockStart", s[4], 1'b0);
    flush();
  endtask

  task automatic testNinth();
    logic [7:0] s;
    @(negedge clk); syncNineMode = 1; ioLine = 1; ninthEdge = 1;
    @(negedge clk); ninthEdge = 0;
    readStat(s);
    chk("R12 ninth latched", s[6], 1'b1);
    @(negedge clk); syncNineMode = 0; ioLine = 0; ninthEdge = 1;
    @(negedge clk); ninthEdge = 0;
    readStat(s);
    chk("R12 ignored outside mode", s[6], 1'b1);
    @(negedge clk); syncNineMode = 1; ninthEdge = 1;
    @(negedge clk); ninthEdge = 0;
    readStat(s);
    chk("R12 ninth zero", s[6], 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testFifo();
    testOverrun();
    testParity();
    testCrc();
    testLrc();
    testNinth();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule